// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the multicycle control unit of a small accumulator machine. It walks each instruction through a fetch, an optional indirect-address resolution, an execute step and an interrupt check. It moves data through a program counter, a memory address register, a memory buffer register and an instruction register. A single-port synchronous memory outside the block is reached through one address bus and separate read and write strobes.

A status word carries five condition flags plus an interrupt-enable bit and a supervisor bit. Loads, additions, subtractions and compares update the flags. The conditional jumps test them.

An external request line is honoured only at the interrupt check, and only while interrupts are enabled. Taking an interrupt stores the program counter in a fixed save word through the buffer register. Control then passes to a fixed handler address. A return opcode reloads the saved counter.

Top module: `icc_seq`

## Requirements
- R1: While reset is low, the program counter reads 0x010, the accumulator reads 0, the status word reads 0x40 (only the supervisor bit set), and neither memory strobe is active.
- R2: Fetch is a sequence of three cycles. The address register is loaded from the program counter. In the next cycle the read strobe is raised with that address. One cycle later the read word is captured into the buffer and instruction registers, and the program counter steps by one. The first read after reset therefore appears in the second cycle after release, at address 0x010.
- R3: An instruction word is laid out as follows: bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 hold the address. The opcodes are 0 no-op, 1 load, 2 store, 3 add, 4 subtract, 5 compare, 6 jump, 7 jump-if-zero, 8 jump-if-carry, 9 enable interrupts, 10 disable interrupts and 11 return from interrupt. Codes 12 to 15 act as no-ops.
- R4: When bit 11 is set, the block reads the word at the address field. The low 11 bits of that word become the effective address.
- R5: Add and subtract write the accumulator and set four flags. Carry (status bit 0) is the carry out, or for subtract the borrow. Zero (bit 1) marks a zero result. Sign (bit 2) copies result bit 15. Overflow (bit 3) marks a signed overflow.
- R6: Load writes the operand to the accumulator and updates only zero and sign. Compare leaves the accumulator unchanged and updates only the equal flag (bit 4), which is set exactly when the accumulator equals the operand.
- R7: Store writes the accumulator to the effective address.
- R8: Jump loads the program counter with the effective address. Jump-if-zero does so only when the zero flag is set, and jump-if-carry only when the carry flag is set.
- R9: At the interrupt check, a high request line is taken only when interrupt-enable (status bit 5) is set. Otherwise the request has no effect and the next fetch follows.
- R10: Taking an interrupt has four effects. The program counter is written to address 0x000. The program counter becomes 0x001. Interrupt-enable is cleared. Supervisor (status bit 6) is set.
- R11: Return from interrupt loads the program counter from the low 11 bits of the word at 0x000, sets interrupt-enable and clears supervisor. The enable and disable opcodes set and clear interrupt-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |
| mem_addr | output | 11 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| psw_o | output | 7 | Status word {supervisor, int-enable, equal, overflow, sign, zero, carry} |

## Verification
The assertions rely on the memory returning the addressed word exactly one cycle after the read strobe, with no wait. The bench memory model registers its read port on the same edge as the write port, so this always holds.

The request line is assumed to stay level until the save write is seen. The bench drops it only after it observes that write to address 0x000. This keeps the handler from being re-entered once the return opcode has enabled interrupts again.

Programs are loaded only while reset is held, so the memory contents never change under a running sequence.

// File: rtl/icc_pkg.sv
package icc_pkg;
    typedef enum logic [3:0] {
        S_FI, S_FR, S_FW, S_IA, S_IR, S_IW,
        S_XA, S_XR, S_XW, S_IC, S_VA, S_VW
    } state_e;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0, OP_LDA = 4'd1, OP_STA = 4'd2, OP_ADD = 4'd3,
        OP_SUB = 4'd4, OP_CMP = 4'd5, OP_JMP = 4'd6, OP_JZ  = 4'd7,
        OP_JC  = 4'd8, OP_EI  = 4'd9, OP_DI  = 4'd10, OP_RTI = 4'd11
    } opc_e;

    typedef struct packed {
        logic sup;
        logic ie;
        logic e;
        logic v;
        logic s;
        logic z;
        logic c;
    } psw_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_st;
        logic jump;
        logic set_ie;
        logic clr_ie;
        logic ret;
    } dec_t;
endpackage

// File: rtl/icc_decode.sv
module icc_decode
    import icc_pkg::*;
(
    input  opc_e op,
    input  psw_t psw,
    output dec_t dec
);
    always_comb begin
        dec = '0;
        case (op)
            OP_LDA, OP_ADD, OP_SUB, OP_CMP: dec.mem_rd = 1'b1;
            OP_RTI: begin
                dec.mem_rd = 1'b1;
                dec.ret    = 1'b1;
            end
            OP_STA: dec.mem_st = 1'b1;
            OP_JMP: dec.jump   = 1'b1;
            OP_JZ:  dec.jump   = psw.z;
            OP_JC:  dec.jump   = psw.c;
            OP_EI:  dec.set_ie = 1'b1;
            OP_DI:  dec.clr_ie = 1'b1;
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/icc_alu.sv
module icc_alu
    import icc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opc_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  psw_t          f_in,
    output logic [DW-1:0] res,
    output psw_t          f_out,
    output logic          acc_we
);
    logic [DW:0] sum;
    logic [DW:0] dif;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        dif    = {1'b0, a} - {1'b0, b};
        res    = a;
        f_out  = f_in;
        acc_we = 1'b0;
        case (op)
            OP_LDA: begin
                res     = b;
                acc_we  = 1'b1;
                f_out.z = (b == '0);
                f_out.s = b[DW-1];
            end
            OP_ADD: begin
                res     = sum[DW-1:0];
                acc_we  = 1'b1;
                f_out.c = sum[DW];
                f_out.v = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
                f_out.z = (sum[DW-1:0] == '0);
                f_out.s = sum[DW-1];
            end
            OP_SUB: begin
                res     = dif[DW-1:0];
                acc_we  = 1'b1;
                f_out.c = dif[DW];
                f_out.v = (a[DW-1] != b[DW-1]) && (dif[DW-1] != a[DW-1]);
                f_out.z = (dif[DW-1:0] == '0);
                f_out.s = dif[DW-1];
            end
            OP_CMP: f_out.e = (a == b);
            default: ;
        endcase
    end

    always_comb begin
        // R5
        if (op == OP_ADD && f_out.v)
            add_ovf_chk: assert (res[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/icc_seq.sv
module icc_seq
    import icc_pkg::*;
#(
    parameter int DW        = 16,
    parameter int RESET_PC  = 16,
    parameter int VEC_ADDR  = 1,
    parameter int SAVE_ADDR = 0,
    localparam int AW       = DW - 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o,
    output logic [6:0]    psw_o
);
    typedef struct packed {
        state_e        st;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
        psw_t          psw;
    } regs_t;

    regs_t         r_q, r_d;
    dec_t          dec;
    opc_e          op;
    logic [DW-1:0] alu_res;
    psw_t          alu_flags;
    logic          alu_we;
    logic [AW-1:0] ea;

    assign op = opc_e'(r_q.ir[DW-1:DW-4]);
    assign ea = r_q.mbr[AW-1:0];

    icc_decode u_dec (.op(op), .psw(r_q.psw), .dec(dec));

    icc_alu #(.DW(DW)) u_alu (
        .op(op), .a(r_q.acc), .b(mem_rdata), .f_in(r_q.psw),
        .res(alu_res), .f_out(alu_flags), .acc_we(alu_we)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_FI: begin
                r_d.mar = r_q.pc;
                r_d.st  = S_FR;
            end
            S_FR: r_d.st = S_FW;
            S_FW: begin
                r_d.mbr = mem_rdata;
                r_d.ir  = mem_rdata;
                r_d.pc  = r_q.pc + 1'b1;
                r_d.st  = mem_rdata[AW] ? S_IA : S_XA;
            end
            S_IA: begin
                r_d.mar = r_q.mbr[AW-1:0];
                r_d.st  = S_IR;
            end
            S_IR: r_d.st = S_IW;
            S_IW: begin
                r_d.mbr = mem_rdata;
                r_d.st  = S_XA;
            end
            S_XA: begin
                if (dec.mem_rd) begin
                    r_d.mar = dec.ret ? AW'(SAVE_ADDR) : ea;
                    r_d.st  = S_XR;
                end else if (dec.mem_st) begin
                    r_d.mar = ea;
                    r_d.mbr = r_q.acc;
                    r_d.st  = S_XR;
                end else begin
                    if (dec.jump)   r_d.pc     = ea;
                    if (dec.set_ie) r_d.psw.ie = 1'b1;
                    if (dec.clr_ie) r_d.psw.ie = 1'b0;
                    r_d.st = S_IC;
                end
            end
            S_XR: r_d.st = dec.mem_st ? S_IC : S_XW;
            S_XW: begin
                if (dec.ret) begin
                    r_d.pc      = mem_rdata[AW-1:0];
                    r_d.psw.ie  = 1'b1;
                    r_d.psw.sup = 1'b0;
                end else begin
                    r_d.psw = alu_flags;
                    if (alu_we) r_d.acc = alu_res;
                end
                r_d.st = S_IC;
            end
            S_IC: r_d.st = (r_q.psw.ie && irq) ? S_VA : S_FI;
            S_VA: begin
                r_d.mar = AW'(SAVE_ADDR);
                r_d.mbr = {{(DW-AW){1'b0}}, r_q.pc};
                r_d.st  = S_VW;
            end
            S_VW: begin
                r_d.pc      = AW'(VEC_ADDR);
                r_d.psw.ie  = 1'b0;
                r_d.psw.sup = 1'b1;
                r_d.st      = S_FI;
            end
            default: r_d.st = S_FI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= S_FI;
            r_q.pc      <= AW'(RESET_PC);
            r_q.psw.sup <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mbr;
    assign mem_rd    = (r_q.st == S_FR) || (r_q.st == S_IR) ||
                       (r_q.st == S_XR && !dec.mem_st);
    assign mem_wr    = (r_q.st == S_XR && dec.mem_st) || (r_q.st == S_VW);
    assign pc_o      = r_q.pc;
    assign acc_o     = r_q.acc;
    assign psw_o     = r_q.psw;

    // R2
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FR) |-> (mem_rd && mem_addr == r_q.pc));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FW) |=> (r_q.pc == $past(r_q.pc) + 1'b1));

    // R4
    ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IR) |-> (r_q.ir[AW] && mem_rd && mem_addr == r_q.ir[AW-1:0]));

    // R9
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IC && !r_q.psw.ie) |=> (r_q.st == S_FI));

    // R10
    save_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_VW) |-> (mem_wr && mem_addr == AW'(SAVE_ADDR) &&
                              mem_wdata[AW-1:0] == r_q.pc));

    // R10
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_VW) |=> (r_q.pc == AW'(VEC_ADDR) && !r_q.psw.ie && r_q.psw.sup));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/sim_icc_seq.sv
module sim_icc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata;
    logic [10:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [10:0] pc_o;
    logic [15:0] acc_o;
    logic [6:0]  psw_o;

    logic        tb_clr = 1'b0;
    logic        tb_we = 1'b0;
    logic [10:0] tb_addr = '0;
    logic [15:0] tb_data = '0;
    logic [15:0] mem [0:2047];

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    icc_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .pc_o(pc_o), .acc_o(acc_o), .psw_o(psw_o)
    );

    always_ff @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 2048; i++) mem[i] <= '0;
        end else if (tb_we) begin
            mem[tb_addr] <= tb_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // {opcode word, a, b, expected acc, expected status}
    localparam logic [79:0] VEC [0:7] = '{
        {16'h3000, 16'h0001, 16'h0002, 16'h0003, 16'h0040},
        {16'h3000, 16'hFFFF, 16'h0001, 16'h0000, 16'h0043},
        {16'h3000, 16'h7FFF, 16'h0001, 16'h8000, 16'h004C},
        {16'h4000, 16'h0005, 16'h0007, 16'hFFFE, 16'h0045},
        {16'h4000, 16'h8000, 16'h0001, 16'h7FFF, 16'h0048},
        {16'h5000, 16'h1234, 16'h1234, 16'h1234, 16'h0050},
        {16'h5000, 16'h1234, 16'h1235, 16'h1234, 16'h0040},
        {16'h1000, 16'h8000, 16'h0000, 16'h0000, 16'h0042}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        tb_addr = a;
        tb_data = d;
        tb_we   = 1'b1;
        @(negedge clk);
        tb_we   = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        @(negedge clk);
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit seen_save;
        bit seen_hnd;

        // R1: reset state
        hold_reset();
        chk("R1 pc", 32'(pc_o), 32'h010);
        chk("R1 acc", 32'(acc_o), 32'h0);
        chk("R1 psw", 32'(psw_o), 32'h40);
        chk("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'h0);

        // R5 R6: vector table, program LDA a; OP b; JMP self (R3 layout)
        foreach (VEC[k]) begin
            hold_reset();
            poke(11'h010, 16'h1100);
            poke(11'h011, VEC[k][79:64] | 16'h0101);
            poke(11'h012, 16'h6012);
            poke(11'h100, VEC[k][63:48]);
            poke(11'h101, VEC[k][47:32]);
            rst_n = 1'b1;
            run(120);
            chk((VEC[k][79:76] == 4'h3 || VEC[k][79:76] == 4'h4) ? "R5 acc" : "R6 acc",
                32'(acc_o), 32'(VEC[k][31:16]));
            chk((VEC[k][79:76] == 4'h3 || VEC[k][79:76] == 4'h4) ? "R5 psw" : "R6 psw",
                32'(psw_o), 32'(VEC[k][15:0]));
        end

        // R2 R4 R7: fetch timing, indirect load and indirect store
        hold_reset();
        poke(11'h010, 16'h1905);
        poke(11'h011, 16'h2907);
        poke(11'h012, 16'h6012);
        poke(11'h105, 16'h0106);
        poke(11'h106, 16'hBEEF);
        poke(11'h107, 16'h0120);
        rst_n = 1'b1;
        run(1);
        chk("R2 first read strobe", 32'(mem_rd), 32'h1);
        chk("R2 first read addr", 32'(mem_addr), 32'h010);
        run(2);
        chk("R2 pc step", 32'(pc_o), 32'h011);
        run(120);
        chk("R4 indirect load", 32'(acc_o), 32'hBEEF);
        chk("R7 indirect store", 32'(mem[11'h120]), 32'hBEEF);

        // R8: jump-if-zero taken
        hold_reset();
        poke(11'h010, 16'h1100);
        poke(11'h011, 16'h7016);
        poke(11'h012, 16'h1101);
        poke(11'h013, 16'h6013);
        poke(11'h016, 16'h6016);
        poke(11'h101, 16'h1111);
        rst_n = 1'b1;
        run(120);
        chk("R8 jz taken", 32'(acc_o), 32'h0);

        // R8: jump-if-zero not taken
        hold_reset();
        poke(11'h010, 16'h1100);
        poke(11'h011, 16'h7016);
        poke(11'h012, 16'h1101);
        poke(11'h013, 16'h6013);
        poke(11'h016, 16'h6016);
        poke(11'h100, 16'h0005);
        poke(11'h101, 16'h1111);
        rst_n = 1'b1;
        run(120);
        chk("R8 jz not taken", 32'(acc_o), 32'h1111);

        // R9: request ignored while interrupts disabled
        hold_reset();
        poke(11'h000, 16'hAAAA);
        poke(11'h010, 16'h1100);
        poke(11'h011, 16'h2111);
        poke(11'h012, 16'h6012);
        poke(11'h100, 16'h0055);
        irq = 1'b1;
        rst_n = 1'b1;
        run(120);
        chk("R9 save word untouched", 32'(mem[11'h000]), 32'hAAAA);
        chk("R9 program ran", 32'(mem[11'h111]), 32'h0055);
        chk("R9 psw", 32'(psw_o), 32'h40);
        irq = 1'b0;

        // R10 R11: interrupt taken after enable, handler, return
        hold_reset();
        poke(11'h001, 16'h1101);
        poke(11'h002, 16'h2110);
        poke(11'h003, 16'hB000);
        poke(11'h010, 16'h9000);
        poke(11'h011, 16'h1100);
        poke(11'h012, 16'h2111);
        poke(11'h013, 16'h6013);
        poke(11'h100, 16'h0007);
        poke(11'h101, 16'h0042);
        irq = 1'b1;
        rst_n = 1'b1;
        seen_save = 1'b0;
        seen_hnd  = 1'b0;
        for (int t = 0; t < 200; t++) begin
            run(1);
            if (mem_wr && mem_addr == 11'h000 && !seen_save) begin
                seen_save = 1'b1;
                irq = 1'b0;
                chk("R10 saved pc", 32'(mem_wdata), 32'h0011);
                run(1);
                chk("R10 vector", 32'(pc_o), 32'h001);
                chk("R10 psw in handler", 32'(psw_o), 32'h40);
            end
            if (mem_wr && mem_addr == 11'h110 && !seen_hnd) begin
                seen_hnd = 1'b1;
                chk("R10 handler store data", 32'(mem_wdata), 32'h0042);
            end
        end
        chk("R10 interrupt seen", {30'd0, seen_save, seen_hnd}, 32'h3);
        chk("R11 resumed store", 32'(mem[11'h111]), 32'h0007);
        chk("R11 acc", 32'(acc_o), 32'h0007);
        chk("R11 psw after return", 32'(psw_o), 32'h20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule